// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Stop Gate

This block produces a group of derived clock outputs from a fast base clock and can halt the stoppable ones in response to an active-low asynchronous stop request. Each derived output has a fixed period of `2*HALF` base clock cycles. The block makes a single run-or-halt decision at each output cycle boundary, which is the base clock edge where a new high phase would begin. Because the decision is only taken there, a halted output rests low and every high phase it produces lasts the full `HALF` cycles.

The stop request first passes through a synchronizer of `SYNC_STAGES` flops in the base clock domain. After every restart, and after reset, the gate lets at least `MIN_RUN` output cycles run before it honours a stop. A stop that is seen during that window is held pending and takes effect at the first boundary after the window closes. Each output also has its own enable bit, sampled at the boundary, and a disabled output stays low. One free output follows its enable bit but never reacts to the stop request. A tri-state control clears the registered pad output enable and leaves the clocks running.

Top module: `clkstop_gate`

## Requirements
- R1: After reset is released, the first base clock edge starts an output cycle. Every output cycle is `HALF` edges high followed by `HALF` edges low, on every enabled, granted output.
- R2: An output cycle that is not granted leaves every gated output low for the whole cycle.
- R3: A gated output rises only at an output cycle boundary. Each of its high phases lasts exactly `HALF` base clock cycles.
- R4: Once the outputs start after reset or after a halt, at least `MIN_RUN` consecutive output cycles are granted before a stop can take effect.
- R5: Suppose `stop_req_n` changes within the first base clock period after a boundary, with `SYNC_STAGES`=2 and `HALF`=2. A fall halts the outputs at the next boundary once the window is satisfied. A rise grants the next boundary again.
- R6: A stop request seen for as little as one synchronized cycle while the minimum-run window is still open is held. It suppresses exactly one output cycle, at the first boundary after the window. If the request is gone by then, the outputs run again at the following boundary.
- R7: `free_clk` keeps toggling per R1 while the stoppable outputs are halted.
- R8: Bit i of `lane_en` (and `free_en` for the free output) is sampled at each boundary. When it is 0 that output is low for the whole output cycle.
- R9: `pad_oe` equals the inverse of `tristate` one base clock edge later. `tristate` has no effect on the clock outputs.
- R10: While `rst_n` is low, `gated_clk`, `free_clk` and `pad_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock that all derived outputs are built from |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request for the stoppable outputs |
| lane_en | input | NUM_GATED | Per-output enable for the stoppable outputs, 1 = may toggle |
| free_en | input | 1 | Enable for the free output |
| tristate | input | 1 | 1 clears the pad output enable |
| gated_clk | output | NUM_GATED | Stoppable derived clock outputs |
| free_clk | output | 1 | Derived clock output that ignores the stop request |
| pad_oe | output | 1 | Registered output enable for the group's pads |

## Verification
Two decisions can land on the same boundary. One is the halt decision: a held stop meets the expiry of the minimum-run window. The other is a change of per-output enables, which applies at that same edge. The bench provokes this by applying enable patterns and stop levels in the same output cycle, right after a restart. It also sends a one-cycle stop pulse inside the window. A scoreboard computes the expected pattern for each output cycle from the window count, the pending flag and the enables. That pattern is then compared in both high-phase samples and both low-phase samples of the cycle.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic {
    GATE_RUN  = 1'b0,
    GATE_HALT = 1'b1
  } gate_state_e;

  // Advance a phase counter that wraps after the last value.
  function automatic int phase_advance(int cur, int last);
    return (cur >= last) ? 0 : cur + 1;
  endfunction

  // A phase count below the half period means the output is high.
  function automatic bit phase_is_high(int cnt, int half);
    return cnt < half;
  endfunction

  // Run-length counter that stops at its limit.
  function automatic int sat_inc(int cur, int lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);

  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b1;
        else        s_q <= async_n;
      end
      assign sync_n = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], async_n};
      end
      assign sync_n = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/clkstop_phase.sv
module clkstop_phase
  import clkstop_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rise_evt,
  output logic hi_next
);

  localparam int PERIOD = 2 * HALF;
  localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // The next edge opens a new output cycle.
  assign rise_evt = (cnt_q == CW'(PERIOD - 1));
  assign cnt_d    = CW'(phase_advance(32'(cnt_q), PERIOD - 1));
  assign hi_next  = phase_is_high(32'(cnt_d), HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(PERIOD - 1);
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int MIN_RUN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic stop_s,
  output logic grant_next
);

  localparam int RW = $clog2(MIN_RUN + 1);

  gate_state_e   st_q;
  logic [RW-1:0] run_q;
  logic          pend_q;
  logic          win_done;
  logic          take_stop;
  logic          resume;

  assign win_done   = (run_q >= RW'(MIN_RUN));
  assign take_stop  = (st_q == GATE_RUN) && (stop_s || pend_q) && win_done;
  assign resume     = (st_q == GATE_HALT) && !stop_s;
  assign grant_next = (st_q == GATE_RUN) ? !take_stop : resume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GATE_RUN;
      run_q  <= '0;
      pend_q <= 1'b0;
    end else if (rise_evt) begin
      if (st_q == GATE_RUN) begin
        if (take_stop) begin
          st_q   <= GATE_HALT;
          pend_q <= 1'b0;
        end else begin
          run_q  <= RW'(sat_inc(32'(run_q), MIN_RUN));
          pend_q <= pend_q | stop_s;
        end
      end else if (resume) begin
        st_q   <= GATE_RUN;
        run_q  <= RW'(1);
        pend_q <= 1'b0;
      end
    end else if ((st_q == GATE_RUN) && stop_s) begin
      pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/clkstop_lane.sv
module clkstop_lane #(
  parameter bit STOPPABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic hi_next,
  input  logic grant_next,
  input  logic en,
  output logic clk_o
);

  logic arm_q;
  logic arm_now;

  assign arm_now = en & (STOPPABLE ? grant_next : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      clk_o <= 1'b0;
    end else begin
      if (rise_evt) arm_q <= arm_now;
      clk_o <= hi_next & (rise_evt ? arm_now : arm_q);
    end
  end

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int NUM_GATED   = 4,
  parameter int HALF        = 2,
  parameter int MIN_RUN     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stop_req_n,
  input  logic [NUM_GATED-1:0] lane_en,
  input  logic                 free_en,
  input  logic                 tristate,
  output logic [NUM_GATED-1:0] gated_clk,
  output logic                 free_clk,
  output logic                 pad_oe
);

  localparam int NLANE = NUM_GATED + 1;

  // Named internal events, also observed by the checker.
  logic             sync_n;
  logic             stop_s;
  logic             rise_evt;
  logic             hi_next;
  logic             grant_next;
  logic [NLANE-1:0] en_all;
  logic [NLANE-1:0] lane_clk;
  logic             pad_oe_q;

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_n(stop_req_n), .sync_n(sync_n)
  );

  assign stop_s = ~sync_n;

  clkstop_phase #(.HALF(HALF)) u_phase (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .hi_next(hi_next)
  );

  clkstop_ctrl #(.MIN_RUN(MIN_RUN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .stop_s(stop_s),
    .grant_next(grant_next)
  );

  assign en_all = {free_en, lane_en};

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      clkstop_lane #(.STOPPABLE(g < NUM_GATED)) u_lane (
        .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .hi_next(hi_next),
        .grant_next(grant_next), .en(en_all[g]), .clk_o(lane_clk[g])
      );
    end
  endgenerate

  assign gated_clk = lane_clk[NUM_GATED-1:0];
  assign free_clk  = lane_clk[NUM_GATED];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pad_oe_q <= 1'b0;
    else        pad_oe_q <= ~tristate;
  end

  assign pad_oe = pad_oe_q;

endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
  parameter int N       = 4,
  parameter int HALF    = 2,
  parameter int MIN_RUN = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] gated,
  input logic         free_clk,
  input logic         rise_evt,
  input logic         grant_next,
  input logic         tristate,
  input logic         pad_oe
);

  localparam int HW = $clog2(HALF + 2) + 1;
  localparam int RW = $clog2(MIN_RUN + 2) + 1;

  logic [HW-1:0] hcnt;
  logic [RW-1:0] rcnt;
  logic          last_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt <= '0;
    else if (gated[0]) hcnt <= hcnt + 1'b1;
    else hcnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt       <= '0;
      last_grant <= 1'b0;
    end else if (rise_evt) begin
      last_grant <= grant_next;
      if (!grant_next) rcnt <= '0;
      else if (rcnt < RW'(MIN_RUN)) rcnt <= rcnt + 1'b1;
    end
  end

  assert_full_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gated[0]) |-> (hcnt == HW'(HALF)));

  assert_rise_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((gated & ~$past(gated)) != '0) |-> $past(rise_evt));

  assert_halt_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !grant_next) |=> (gated == '0));

  assert_min_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && !grant_next && last_grant) |-> (rcnt >= RW'(MIN_RUN)));

  assert_free_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(free_clk) |-> $past(rise_evt));

  assert_tristate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tristate |=> !pad_oe);

  assert_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tristate |=> pad_oe);

endmodule

bind clkstop_gate clkstop_gate_chk #(
  .N(NUM_GATED), .HALF(HALF), .MIN_RUN(MIN_RUN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gated(gated_clk), .free_clk(free_clk),
  .rise_evt(rise_evt), .grant_next(grant_next), .tristate(tristate),
  .pad_oe(pad_oe)
);

// File: tb/clkstop_gate_tb.sv
`timescale 1ns/1ps
module clkstop_gate_tb;

  localparam int N    = 4;
  localparam int HALF = 2;
  localparam int P    = 2 * HALF;
  localparam int MINR = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stop_req_n = 1'b1;
  logic [N-1:0] lane_en = '1;
  logic         free_en = 1'b1;
  logic         tristate = 1'b0;
  logic [N-1:0] gated_clk;
  logic         free_clk;
  logic         pad_oe;

  int checks = 0;
  int fails  = 0;
  int ecnt   = 0;
  bit drv_done = 1'b0;
  bit reported = 1'b0;

  // Scoreboard queues: expected {free, gated} per output cycle, and a tag.
  logic [N:0] exp_q[$];
  string      tag_q[$];

  // Bench-side model state, at output-cycle granularity.
  bit m_halt = 1'b0;
  int m_run  = 0;
  bit m_pend = 1'b0;

  clkstop_gate #(.NUM_GATED(N), .HALF(HALF), .MIN_RUN(MINR), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .lane_en(lane_en),
    .free_en(free_en), .tristate(tristate), .gated_clk(gated_clk),
    .free_clk(free_clk), .pad_oe(pad_oe)
  );

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  task automatic check(input bit ok, input string tag, input logic [N:0] act,
                       input logic [N:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Model of one output cycle; pushes the expected pattern.
  task automatic push_cycle(input bit lvl, input bit pulse, input logic [N-1:0] en,
                            input bit fen, input string tag);
    bit grant;
    bit seen;
    if (!m_halt) begin
      seen = lvl | pulse | m_pend;
      if (seen && m_run >= MINR) begin
        m_halt = 1'b1; grant = 1'b0; m_pend = 1'b0;
      end else begin
        grant = 1'b1;
        m_run = (m_run >= MINR) ? MINR : m_run + 1;
        m_pend = seen;
      end
    end else if (!lvl) begin
      m_halt = 1'b0; grant = 1'b1; m_run = 1; m_pend = 1'b0;
    end else begin
      grant = 1'b0;
    end
    exp_q.push_back({fen, grant ? en : {N{1'b0}}});
    tag_q.push_back(tag);
  endtask

  // Driver: called right after a boundary edge, sets inputs for the next one.
  task automatic step(input bit lvl, input bit pulse, input logic [N-1:0] en,
                      input bit fen, input bit tri_v, input string tag);
    stop_req_n = ~(lvl | pulse);
    lane_en    = en;
    free_en    = fen;
    tristate   = tri_v;
    push_cycle(lvl, pulse, en, fen, tag);
    @(negedge clk);
    if (pulse) stop_req_n = 1'b1;
    check(pad_oe == ~tri_v, "R9 pad_oe", {{N{1'b0}}, pad_oe}, {{N{1'b0}}, ~tri_v});
    do @(negedge clk); while (!(ecnt > 0 && ((ecnt - 1) % P) == 0));
  endtask

  // Monitor: pops the expected item at each boundary and compares all phases.
  logic [N:0] cur;
  string      cur_tag;
  bit         have = 1'b0;
  always @(negedge clk) begin
    if (rst_n && ecnt > 0) begin
      int off;
      off = (ecnt - 1) % P;
      if (off == 0) begin
        if (exp_q.size() > 0) begin
          cur = exp_q.pop_front();
          cur_tag = tag_q.pop_front();
          have = 1'b1;
        end else begin
          have = 1'b0;
          if (!drv_done) check(1'b0, "R1 scoreboard empty", '0, '1);
        end
      end
      if (have) begin
        if (off < HALF)
          check({free_clk, gated_clk} == cur, {cur_tag, " high phase"},
                {free_clk, gated_clk}, cur);
        else
          check({free_clk, gated_clk} == '0, {cur_tag, " R3 low phase"},
                {free_clk, gated_clk}, '0);
      end
    end
  end

  initial begin
    #160000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check({free_clk, gated_clk} == '0, "R10 clocks in reset", {free_clk, gated_clk}, '0);
    check(pad_oe == 1'b0, "R10 pad_oe in reset", {{N{1'b0}}, pad_oe}, '0);
    push_cycle(1'b0, 1'b0, 4'b1111, 1'b1, "R1 first cycle");
    rst_n = 1'b1;
    do @(negedge clk); while (!(ecnt > 0 && ((ecnt - 1) % P) == 0));
    // R1: steady running
    for (int i = 0; i < 3; i++) step(0, 0, 4'b1111, 1, 0, "R1 run");
    // R8: per-output enables
    step(0, 0, 4'b0101, 1, 0, "R8 en 0101");
    step(0, 0, 4'b1010, 1, 0, "R8 en 1010");
    step(0, 0, 4'b0000, 0, 0, "R8 all off");
    step(0, 0, 4'b1000, 1, 0, "R8 en 1000");
    // R9: tristate leaves clocks alone
    step(0, 0, 4'b1111, 1, 1, "R9 tristate");
    step(0, 0, 4'b1111, 1, 1, "R9 tristate");
    // R5 / R2 / R7: halt with window satisfied, free keeps running
    step(1, 0, 4'b1111, 1, 0, "R5 stop");
    for (int i = 0; i < 3; i++) step(1, 0, 4'b1111, 1, 0, "R2 R7 halted");
    step(1, 0, 4'b0110, 0, 0, "R8 free off while halted");
    step(0, 0, 4'b1111, 1, 0, "R5 restart");
    // R4: stop held right after restart
    for (int i = 0; i < 12; i++) step(1, 0, 4'b1111, 1, 0, "R4 window");
    step(0, 0, 4'b1111, 1, 0, "R5 restart");
    step(0, 0, 4'b0011, 1, 0, "R8 after restart");
    // R6: short request inside the window
    step(0, 1, 4'b1111, 1, 0, "R6 pulse");
    for (int i = 0; i < 11; i++) step(0, 0, 4'b1111, 1, 0, "R6 pending");
    drv_done = 1'b1;
    repeat (2 * P) @(negedge clk);
    finish_run();
  end

endmodule